// File: doc/BRIEF.md
# Iterative Population Count Engine

This block counts how many bits are set in a WIDTH-bit operand by walking the word one bit per clock instead of summing it in a wide adder tree. While the engine is idle it keeps sampling the data input into an internal shift register and keeps its tally at zero. Raising `start` freezes the captured word. The engine then moves the word right one place each cycle and adds one to the tally whenever the bit leaving the bottom is set. It stops as soon as the remaining word is all zeros, so a word with only low-order bits set finishes quickly.

The handshake uses plain control pins. The requester sets `data_in` and keeps `start` low for at least one cycle so the word is captured. It then raises `start` and holds it high. When the result is ready the engine raises `done` and keeps both `done` and `count` steady until `start` is lowered. One cycle after that, the engine is idle again and accepts the next word. There is no back-pressure on the result: the requester consumes it by releasing `start`, and it can take as long as it needs to do so.

The tally is one bit wider than log2(WIDTH), so an all-ones operand gives WIDTH without wrapping. Reset is asynchronous and active high.

Top module: `bitcount_engine`

## Requirements
- R1: While `rst` is high, and after it is released with `start` low, `done` is 0 and `count` is 0.
- R2: In the idle state with `start` low, the operand register takes `data_in` on every clock edge. The word counted is the one present at the last edge before the edge that samples `start` high.
- R3: When `done` is 1, `count` equals the number of 1 bits in the captured word. `count` is $clog2(WIDTH)+1 bits wide and reaches WIDTH for an all-ones word without wrapping.
- R4: Number the rising edges from the one that first samples `start` high as edge 1. For a nonzero word whose highest set bit is at position k (bit 0 being the least significant), `done` first reads 1 after edge k+3.
- R5: An all-zero word completes with `count` 0, and `done` first reads 1 after edge 2 (one cycle spent counting).
- R6: While `done` is 1 and `start` stays 1, `done` stays 1 and `count` does not change.
- R7: With `done` at 1, lowering `start` makes `done` read 0 after the next edge. The engine is then idle and counts a new word correctly.
- R8: Changes on `data_in` after `start` has been sampled high have no effect on the result.
- R9: From one cycle to the next, `count` either keeps its value, rises by exactly one, or returns to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Asynchronous reset, active high |
| start | input | 1 | Request; held high for the whole run and released after `done` |
| data_in | input | WIDTH | Word to be counted, sampled while idle |
| done | output | 1 | Result ready; held until `start` falls |
| count | output | $clog2(WIDTH)+1 | Number of set bits, valid while `done` is 1 |

## Verification
The bench builds the engine with WIDTH set to 8, so the tally is four bits wide. At this width the bench can sweep all 256 operand values. This covers the all-zero word, the all-ones word that drives the tally to its ceiling, and every position of the highest set bit, each of which sets a different run length. Separate directed scenarios keep `start` high well past completion, change the input while a count is in progress, and issue requests back to back right after a release.

// File: rtl/bitcount_pkg.sv
package bitcount_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_COUNT = 2'd1,
    ST_DONE  = 2'd2
  } bc_state_e;

  function automatic int tally_width(input int word_bits);
    return $clog2(word_bits) + 1;
  endfunction

endpackage

// File: rtl/bc_operand_reg.sv
module bc_operand_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         shift,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      q <= '0;
    end else if (load) begin
      q <= d;
    end else if (shift) begin
      q <= {1'b0, q[W-1:1]};
    end
  end

endmodule

// File: rtl/bc_tally.sv
module bc_tally #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] q
);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      q <= '0;
    end else if (clr) begin
      q <= '0;
    end else if (inc) begin
      q <= q + 1'b1;
    end
  end

endmodule

// File: rtl/bc_ctrl.sv
module bc_ctrl
  import bitcount_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic opnd_zero,
  input  logic opnd_lsb,
  output logic load_op,
  output logic shift_op,
  output logic clr_cnt,
  output logic inc_cnt,
  output logic busy,
  output logic done
);

  bc_state_e state_q, state_d;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start)     state_d = ST_COUNT;
      ST_COUNT: if (opnd_zero) state_d = ST_DONE;
      ST_DONE:  if (!start)    state_d = ST_IDLE;
      default:                 state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    load_op  = (state_q == ST_IDLE) && !start;
    clr_cnt  = (state_q == ST_IDLE);
    shift_op = (state_q == ST_COUNT);
    inc_cnt  = (state_q == ST_COUNT) && !opnd_zero && opnd_lsb;
    busy     = (state_q == ST_COUNT);
    done     = (state_q == ST_DONE);
  end

endmodule

// File: rtl/bitcount_engine.sv
module bitcount_engine
  import bitcount_pkg::*;
#(
  parameter int WIDTH = 16,
  localparam int CW = tally_width(WIDTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [WIDTH-1:0] data_in,
  output logic             done,
  output logic [CW-1:0]    count
);

  logic [WIDTH-1:0] opnd_q;
  logic             opnd_zero;
  logic             load_op, shift_op, clr_cnt, inc_cnt, busy;

  assign opnd_zero = ~|opnd_q;

  bc_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .opnd_zero(opnd_zero),
    .opnd_lsb (opnd_q[0]),
    .load_op  (load_op),
    .shift_op (shift_op),
    .clr_cnt  (clr_cnt),
    .inc_cnt  (inc_cnt),
    .busy     (busy),
    .done     (done)
  );

  bc_operand_reg #(.W(WIDTH)) u_opnd (
    .clk  (clk),
    .rst  (rst),
    .load (load_op),
    .shift(shift_op),
    .d    (data_in),
    .q    (opnd_q)
  );

  bc_tally #(.CW(CW)) u_tally (
    .clk(clk),
    .rst(rst),
    .clr(clr_cnt),
    .inc(inc_cnt),
    .q  (count)
  );

endmodule

// File: rtl/bitcount_engine_chk.sv
module bitcount_engine_chk #(
  parameter int WIDTH = 16,
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          done,
  input logic [CW-1:0] count,
  input logic          busy,
  input logic          opnd_zero
);

  localparam logic [CW-1:0] MAX_TALLY = CW'(WIDTH);

  // R1: nothing reported during reset
  always_comb begin
    if (rst) a_r1_reset_quiet: assert (!done);
  end

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    count <= MAX_TALLY);

  a_r5_zero_exit: assert property (@(posedge clk) disable iff (rst)
    (busy && opnd_zero) |=> done);

  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    (done && start) |=> (done && $stable(count)));

  a_r7_release: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> !done);

  a_r9_step: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (count == $past(count) || count == $past(count) + 1'b1 || count == '0));

endmodule

bind bitcount_engine bitcount_engine_chk #(.WIDTH(WIDTH), .CW(CW)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .done     (done),
  .count    (count),
  .busy     (busy),
  .opnd_zero(opnd_zero)
);

// File: tb/bitcount_engine_tb_top.sv
module bitcount_engine_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int W  = 8;
  localparam int CW = $clog2(W) + 1;

  logic          clk = 1'b0;
  logic          rst;
  logic          start;
  logic [W-1:0]  data_in;
  logic          done;
  logic [CW-1:0] count;

  int runs  = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bitcount_engine #(.WIDTH(W)) dut_i (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .data_in(data_in),
    .done   (done),
    .count  (count)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    runs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int ones(input logic [W-1:0] v);
    int n = 0;
    for (int i = 0; i < W; i++) n += v[i];
    return n;
  endfunction

  function automatic int exp_edges(input logic [W-1:0] v);
    int hi = -1;
    for (int i = 0; i < W; i++) if (v[i]) hi = i;
    return (hi < 0) ? 2 : hi + 3;
  endfunction

  // load a word, raise start, return count and edges until done
  task automatic run_word(input logic [W-1:0] v, input logic [W-1:0] later,
                          output int res, output int edges);
    data_in = v;
    start   = 1'b0;
    @(negedge clk);
    start = 1'b1;
    edges = 0;
    for (int i = 0; i < 4*W + 8; i++) begin
      @(negedge clk);
      data_in = later;
      edges++;
      if (done) break;
    end
    res = int'(count);
  endtask

  task automatic release_start();
    start = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1; start = 1'b0; data_in = '0;
    repeat (2) @(negedge clk);
    check(done == 1'b0, "R1 done in reset", int'(done), 0);
    rst = 1'b0;
    @(negedge clk);
    check(done == 1'b0 && count == '0, "R1 after reset", int'(count), 0);
  endtask

  task automatic t_sweep();
    int res, edges;
    for (int v = 0; v < (1 << W); v++) begin
      run_word(W'(v), W'(v), res, edges);
      if (v == 0) begin
        check(res == 0, "R5 zero count", res, 0);
        check(edges == 2, "R5 zero latency", edges, 2);
      end else begin
        check(res == ones(W'(v)), "R3 count", res, ones(W'(v)));
        check(edges == exp_edges(W'(v)), "R4 latency", edges, exp_edges(W'(v)));
      end
      release_start();
    end
  endtask

  task automatic t_hold();
    int res, edges;
    run_word(8'hB6, 8'hB6, res, edges);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(done == 1'b1, "R6 done held", int'(done), 1);
      check(int'(count) == 5, "R6 count held", int'(count), 5);
    end
    start = 1'b0;
    @(negedge clk);
    check(done == 1'b0, "R7 done clears", int'(done), 0);
  endtask

  task automatic t_ignore_input();
    int res, edges;
    run_word(8'h81, 8'hFF, res, edges);
    check(res == 2, "R8 input ignored", res, 2);
    check(edges == exp_edges(8'h81), "R8 latency", edges, exp_edges(8'h81));
    release_start();
  endtask

  task automatic t_last_sample();
    int res, edges;
    // idle sampling: several words pass, only the last before start counts
    data_in = 8'hFF; start = 1'b0;
    @(negedge clk);
    data_in = 8'h0F;
    @(negedge clk);
    run_word(8'h03, 8'h00, res, edges);
    check(res == 2, "R2 last sample counted", res, 2);
    release_start();
  endtask

  task automatic t_back_to_back();
    int res, edges;
    run_word(8'hFF, 8'hFF, res, edges);
    check(res == W, "R3 all ones", res, W);
    release_start();
    run_word(8'h10, 8'h10, res, edges);
    check(res == 1, "R7 next word", res, 1);
    check(edges == 7, "R7 next latency", edges, 7);
    release_start();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_last_sample();
    t_sweep();
    t_hold();
    t_ignore_input();
    t_back_to_back();
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

endmodule